// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the software-visible register file of an interrupt routing controller. A bus master never addresses the internal registers directly. It first writes an index into a select register, then reads or writes a single data window. Behind the window sit three things: an 8-bit controller identifier, a read-only version word that also reports the table size, and a table of 64-bit per-pin routing entries. Each entry is reached as two 32-bit halves at an even/odd index pair.

The routing table is driven out as a flat vector so that a separate dispatcher can use it. Every write to an entry half raises a one-cycle update strobe, together with the entry number, so that the dispatcher re-checks pending interrupts. Sampling of the interrupt pins and delivery of interrupts happen in that dispatcher, not here.

Top module: `irq_route_regfile`

## Requirements
- R1: Only bus address bits 7:0 are decoded; a write to byte offset 0x00 loads the select register and offset 0x10 is the data window. A read at any other offset returns zero, and a write there changes no state.
- R2: The select register holds bus write data bits 7:0. A read at offset 0x00 returns it in bits 7:0 with bits 31:8 zero.
- R3: With index 0 selected, a window write stores data bits 31:24 as the controller ID. A window read returns the ID in bits 31:24 with all other bits zero.
- R4: Index 1 is read-only and returns 0x11 in bits 7:0, PIN_COUNT-1 in bits 23:16 and zero elsewhere. Window writes to index 1 change nothing.
- R5: Index 2 reads as zero and ignores writes. Indices 3 to 0x0F also read as zero and ignore writes.
- R6: An index n of 0x10 or above selects entry (n-0x10)/2. An even n reaches entry bits 31:0 and an odd n reaches bits 63:32. A write replaces only that half. Entry k appears on route_table bits 64k+63:64k.
- R7: An index whose entry number is PIN_COUNT or larger reads as zero, and a write to it changes no state.
- R8: A synchronous reset clears the ID and the select register and sets every entry to 0x0000_0000_0001_0000, which has the mask bit 16 set.
- R9: A window write to an in-range entry half raises upd_strobe for exactly the next cycle, with upd_pin equal to the entry number. The strobe appears in the same cycle that the new value is visible on route_table. No other write raises upd_strobe.
- R10: bus_rvalid is high exactly in the cycle after a cycle with bus_rd high, and it carries the data in bus_rdata. bus_rdata is zero whenever bus_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| route_table | output | PIN_COUNT*64 | All routing entries, entry k at bits 64k+63:64k |
| upd_strobe | output | 1 | One-cycle pulse after an entry half is written |
| upd_pin | output | PIN_W | Entry number that goes with upd_strobe |

## Verification
The cases that are hard to reach are the writes that must do nothing: the read-only version index, the reserved indices and the entries past the end of the table. Their only effect can be a silent corruption of some other register, and a single access gives no sign of it. The bench therefore walks the select register through all 256 values. For each value it writes a distinct pattern through the window and reads the window back. It then compares the whole route_table against an arithmetic model, so a stray write to any entry half, or a missing one, is seen at once. Upper address bits are set on some accesses to show that they alias onto the decoded offsets.

// File: rtl/irq_rw_pkg.sv
package irq_rw_pkg;
  localparam int          DATA_W      = 32;
  localparam int          ENTRY_W     = 64;
  localparam int          IDX_W       = 8;
  localparam int          ENUM_W      = 7;
  localparam logic [7:0]  OFF_SELECT  = 8'h00;
  localparam logic [7:0]  OFF_WINDOW  = 8'h10;
  localparam logic [7:0]  IDX_IDENT   = 8'h00;
  localparam logic [7:0]  IDX_VERSION = 8'h01;
  localparam logic [7:0]  IDX_RSVD    = 8'h02;
  localparam logic [7:0]  IDX_TABLE   = 8'h10;
  localparam logic [7:0]  VERSION_ID  = 8'h11;
  localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_IDENT,
    TGT_VERSION,
    TGT_ZERO,
    TGT_ENTRY
  } win_tgt_e;

  typedef struct packed {
    win_tgt_e          tgt;
    logic [ENUM_W-1:0] entry;
    logic              hi;
  } win_dec_t;

  function automatic logic [DATA_W-1:0] version_word(input int pins);
    logic [7:0] top_entry;
    top_entry = 8'(pins - 1);
    return {8'h00, top_entry, 8'h00, VERSION_ID};
  endfunction
endpackage

// File: rtl/irq_rw_index_decode.sv
module irq_rw_index_decode
  import irq_rw_pkg::*;
#(
  parameter int PIN_COUNT = 24
) (
  input  logic [IDX_W-1:0] sel,
  output win_dec_t         dec
);
  logic [IDX_W-1:0] rel;

  always_comb begin
    rel       = sel - IDX_TABLE;
    dec.entry = rel[IDX_W-1:1];
    dec.hi    = sel[0];
    if (sel == IDX_IDENT)
      dec.tgt = TGT_IDENT;
    else if (sel == IDX_VERSION)
      dec.tgt = TGT_VERSION;
    else if (sel == IDX_RSVD)
      dec.tgt = TGT_ZERO;
    else if (sel >= IDX_TABLE && int'(dec.entry) < PIN_COUNT)
      dec.tgt = TGT_ENTRY;
    else
      dec.tgt = TGT_NONE;
  end
endmodule

// File: rtl/irq_rw_entry_bank.sv
module irq_rw_entry_bank
  import irq_rw_pkg::*;
#(
  parameter int PIN_COUNT = 24,
  parameter int PIN_W     = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PIN_W-1:0]           wr_entry,
  input  logic                       wr_hi,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [PIN_W-1:0]           rd_entry,
  input  logic                       rd_hi,
  output logic [DATA_W-1:0]          rd_half,
  output logic [PIN_COUNT*ENTRY_W-1:0] table_flat,
  output logic                       upd_strobe,
  output logic [PIN_W-1:0]           upd_pin
);
  localparam int HALF_W = ENTRY_W / 2;

  for (genvar k = 0; k < PIN_COUNT; k++) begin : g_entry
    logic [ENTRY_W-1:0] ent_q;
    logic               hit;
    assign hit = wr_en && (int'(wr_entry) == k);
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= ENTRY_RESET;
      end else if (hit) begin
        if (wr_hi) ent_q[ENTRY_W-1:HALF_W] <= wr_data;
        else       ent_q[HALF_W-1:0]       <= wr_data;
      end
    end
    assign table_flat[k*ENTRY_W +: ENTRY_W] = ent_q;
  end

  always_comb begin
    rd_half = '0;
    if (int'(rd_entry) < PIN_COUNT)
      rd_half = table_flat[int'(rd_entry)*ENTRY_W + (rd_hi ? HALF_W : 0) +: HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_strobe <= 1'b0;
      upd_pin    <= '0;
    end else begin
      upd_strobe <= wr_en;
      if (wr_en) upd_pin <= wr_entry;
    end
  end
endmodule

// File: rtl/irq_rw_read_port.sv
module irq_rw_read_port
  import irq_rw_pkg::*;
#(
  parameter int PIN_COUNT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [7:0]        addr_lo,
  input  logic [IDX_W-1:0]  sel,
  input  win_dec_t          dec,
  input  logic [7:0]        ident,
  input  logic [DATA_W-1:0] entry_half,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] win_val;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    case (dec.tgt)
      TGT_IDENT:   win_val = {ident, 24'h0};
      TGT_VERSION: win_val = version_word(PIN_COUNT);
      TGT_ENTRY:   win_val = entry_half;
      default:     win_val = '0;
    endcase
    if (addr_lo == OFF_SELECT)      nxt = {{(DATA_W-IDX_W){1'b0}}, sel};
    else if (addr_lo == OFF_WINDOW) nxt = win_val;
    else                            nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? nxt : '0;
    end
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_rw_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PIN_COUNT = 24,
  parameter int PIN_W     = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic [31:0]                  bus_wdata,
  input  logic                         bus_rd,
  output logic [31:0]                  bus_rdata,
  output logic                         bus_rvalid,
  output logic [PIN_COUNT*64-1:0]      route_table,
  output logic                         upd_strobe,
  output logic [PIN_W-1:0]             upd_pin
);
  logic [7:0]       addr_lo;
  logic [IDX_W-1:0] sel_q;
  logic [7:0]       ident_q;
  win_dec_t         dec;
  logic             win_wr;
  logic             ent_wr;
  logic [31:0]      ent_half;
  logic [PIN_W-1:0] ent_idx;
  logic             unused_addr_hi;
  logic             unused_entry_hi;

  assign addr_lo        = bus_addr[7:0];
  assign unused_addr_hi = ^bus_addr;
  assign unused_entry_hi = ^dec.entry;
  assign win_wr         = bus_wr && (addr_lo == OFF_WINDOW);
  assign ent_wr         = win_wr && (dec.tgt == TGT_ENTRY);
  assign ent_idx        = dec.entry[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (bus_wr && addr_lo == OFF_SELECT) sel_q <= bus_wdata[IDX_W-1:0];
      if (win_wr && dec.tgt == TGT_IDENT)  ident_q <= bus_wdata[31:24];
    end
  end

  irq_rw_index_decode #(.PIN_COUNT(PIN_COUNT)) u_dec (
    .sel (sel_q),
    .dec (dec)
  );

  irq_rw_entry_bank #(.PIN_COUNT(PIN_COUNT), .PIN_W(PIN_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ent_wr),
    .wr_entry   (ent_idx),
    .wr_hi      (dec.hi),
    .wr_data    (bus_wdata),
    .rd_entry   (ent_idx),
    .rd_hi      (dec.hi),
    .rd_half    (ent_half),
    .table_flat (route_table),
    .upd_strobe (upd_strobe),
    .upd_pin    (upd_pin)
  );

  irq_rw_read_port #(.PIN_COUNT(PIN_COUNT)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (bus_rd),
    .addr_lo    (addr_lo),
    .sel        (sel_q),
    .dec        (dec),
    .ident      (ident_q),
    .entry_half (ent_half),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );
endmodule

// File: rtl/irq_rw_checker.sv
module irq_rw_checker
  import irq_rw_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PIN_COUNT = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [31:0]             bus_rdata,
  input logic                    bus_rvalid,
  input logic [PIN_COUNT*64-1:0] route_table,
  input logic                    upd_strobe,
  input logic [7:0]              sel_q
);
  logic [7:0] a8;
  assign a8 = bus_addr[7:0];

  p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_no_rvalid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  p_rdata_zero_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> bus_rdata == 32'h0);
  p_offset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && a8 != OFF_SELECT && a8 != OFF_WINDOW) |=> bus_rdata == 32'h0);
  p_version_word_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && a8 == OFF_WINDOW && sel_q == IDX_VERSION) |=> bus_rdata == version_word(PIN_COUNT));
  p_table_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && a8 == OFF_WINDOW) |=> $stable(route_table));
  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> $past(bus_wr && a8 == OFF_WINDOW && sel_q >= IDX_TABLE));
endmodule

bind irq_route_regfile irq_rw_checker #(.ADDR_W(ADDR_W), .PIN_COUNT(PIN_COUNT)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .route_table (route_table),
  .upd_strobe  (upd_strobe),
  .sel_q       (sel_q)
);

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb_top;
  localparam int ADDR_W = 12;
  localparam int PINS   = 24;
  localparam int PW     = $clog2(PINS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [PINS*64-1:0] route_table;
  logic              upd_strobe;
  logic [PW-1:0]     upd_pin;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] m_tbl [PINS];
  logic [7:0]  m_id;
  logic [7:0]  m_sel;

  always #4 clk = ~clk;

  irq_route_regfile #(.ADDR_W(ADDR_W), .PIN_COUNT(PINS)) dut_i (
    .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rd,
    .bus_rdata, .bus_rvalid, .route_table, .upd_strobe, .upd_pin
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_window(input logic [7:0] s);
    int e;
    if (s == 8'h00) return {m_id, 24'h0};
    if (s == 8'h01) return {8'h00, 8'(PINS - 1), 8'h00, 8'h11};
    if (s < 8'h10) return 32'h0;
    e = (int'(s) - 16) / 2;
    if (e >= PINS) return 32'h0;
    return s[0] ? m_tbl[e][63:32] : m_tbl[e][31:0];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < PINS; k++) m_tbl[k] = 64'h0000_0000_0001_0000;
    m_id = 8'h0;
    m_sel = 8'h0;
  endtask

  task automatic check_table(input string req);
    logic [PINS*64-1:0] flat;
    for (int k = 0; k < PINS; k++) flat[k*64 +: 64] = m_tbl[k];
    n_tests++;
    if (route_table !== flat) begin
      n_fail++;
      $display("FAIL %s route_table act=%h exp=%h", req, route_table, flat);
    end
  endtask

  // called at a falling edge; returns at the following falling edge
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
    logic [7:0] s;
    int         e;
    bit         strobe_exp;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    s = m_sel;
    e = (int'(s) - 16) / 2;
    strobe_exp = 1'b0;
    if (a[7:0] == 8'h00) m_sel = d[7:0];
    else if (a[7:0] == 8'h10) begin
      if (s == 8'h00) m_id = d[31:24];
      else if (s >= 8'h10 && e < PINS) begin
        strobe_exp = 1'b1;
        if (s[0]) m_tbl[e][63:32] = d;
        else      m_tbl[e][31:0]  = d;
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    check({req, " R9 strobe"}, 64'(upd_strobe), 64'(strobe_exp));
    if (strobe_exp) check("R9 upd_pin", 64'(upd_pin), 64'(e));
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 rvalid", 64'(bus_rvalid), 64'h1);
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    check("R8 strobe", 64'(upd_strobe), 64'h0);
    check("R10 rvalid idle", 64'(bus_rvalid), 64'h0);
    check_table("R8");
    bus_read(12'h000, 32'h0, "R8 select");
    bus_read(12'h010, 32'h0, "R8 ident");
    @(negedge clk);
    check("R10 rvalid drop", 64'(bus_rvalid), 64'h0);
    check("R10 rdata idle", 64'(bus_rdata), 64'h0);

    // R1 decode: other offsets and aliasing of upper address bits
    bus_write(12'h300, 32'hFFFF_FF12, "R2");
    bus_read(12'h000, 32'h12, "R2 select readback");
    bus_read(12'h004, 32'h0, "R1 offset 04");
    bus_read(12'h011, 32'h0, "R1 offset 11");
    bus_read(12'h0FF, 32'h0, "R1 offset ff");
    bus_write(12'h008, 32'hDEAD_BEEF, "R1");
    bus_write(12'h020, 32'h0000_0000, "R1");
    bus_read(12'h100, 32'h12, "R1 select untouched");
    bus_write(12'hA10, 32'h1234_5678, "R1 alias");
    check_table("R1 alias write");
    bus_read(12'h510, exp_window(8'h12), "R1 alias read");

    // R3..R7 sweep over every index
    for (int s = 0; s < 256; s++) begin
      logic [31:0] pat;
      pat = {8'(s) ^ 8'h5A, 8'(s * 3), ~8'(s), 8'(s + 7)};
      bus_write(12'h000, {24'hABCDEF, 8'(s)}, "R2");
      bus_read(12'h000, 32'(s), "R2 select");
      bus_write(12'h010, pat, "R6");
      if (s == 0)       bus_read(12'h010, exp_window(8'(s)), "R3 ident");
      else if (s == 1)  bus_read(12'h010, exp_window(8'(s)), "R4 version");
      else if (s < 16)  bus_read(12'h010, exp_window(8'(s)), "R5 reserved");
      else if ((s - 16) / 2 < PINS) bus_read(12'h010, exp_window(8'(s)), "R6 entry half");
      else              bus_read(12'h010, exp_window(8'(s)), "R7 beyond table");
      check_table(s < 16 ? "R5 table" : "R7 R6 table");
    end
    bus_write(12'h000, 32'h0, "R2");
    bus_read(12'h010, {m_id, 24'h0}, "R3 ident kept");

    // R8 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_table("R8 rerun");
    bus_read(12'h000, 32'h0, "R8 select cleared");
    bus_read(12'h010, 32'h0, "R8 ident cleared");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule